// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Test Port

This block is a small translation lookaside buffer: four ways of eight sets, 32 entries in all. Each entry stores a linear page tag, a valid bit, three attribute bits (dirty, user, write) and a 20-bit physical page number. The array is reached only through a test port with two registers. The data register holds a physical page, a hit flag and a way selector. A command write carries a command bit, a linear page, a valid bit and the attributes, which are given as pairs of a bit and its complement.

A command write with the command bit at 0 stores an entry into the way named by the data register. A command write with the command bit at 1 searches all four ways of the indexed set and loads the result into the data register one clock later. In the same cycle a done pulse marks the result. A flush input invalidates the whole array in one cycle. Way choice is left entirely to software; the block has no replacement policy.

Top module: `tlb_test_port`

## Requirements
- R1: The set index is linear page bits [2:0] and the stored tag is bits [19:3]. Four entries with the same index in different ways coexist and each can be found separately.
- R2: A data-register write (`dat_we`) loads `dat_ppn`, `dat_hit` and `dat_way`. The values appear on `rd_ppn`, `rd_hit` and `rd_way` one clock later.
- R3: A command write with `cmd_op`=0 stores an entry only while the held hit flag is 1. The entry goes to way `rd_way` at the indexed set and takes its physical page from `rd_ppn`. It leaves the data register unchanged, and `rd_apos`/`rd_aneg` take the written pairs. With the held hit flag at 0 the write is ignored.
- R4: A command write with `cmd_op`=1 where exactly one entry matches sets `rd_hit`=1, `rd_ppn` to that entry's page, `rd_way` to its way, `rd_apos` to its stored attributes and `rd_aneg` to their complement. These outputs appear one clock later.
- R5: Attribute bit 2 is dirty, bit 1 is user and bit 0 is write. In a lookup, a pair (pos,neg)=(1,0) requires the stored bit to be 1, (0,1) requires it to be 0, and (0,0) or (1,1) leaves it unconstrained. A write stores 1 only for (1,0) and stores 0 otherwise.
- R6: A lookup compares the valid bit as one more tag bit. `cmd_valid`=1 never matches an invalid entry, and `cmd_valid`=0 matches only invalid entries.
- R7: If more than one way matches, the lookup reports a miss.
- R8: On a miss, `rd_hit`, `rd_ppn` and `rd_way` become 0, and `rd_apos`/`rd_aneg` keep the pairs given with the command.
- R9: `flush` clears every valid bit at the next edge. It wins over an entry write in the same cycle. A later lookup with valid=1 misses.
- R10: `done` is high for exactly the one cycle after each command write, and low otherwise.
- R11: After reset all outputs are 0, and every entry is invalid with zero tag, attributes and page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| dat_we | input | 1 | Data-register write strobe |
| dat_ppn | input | 20 | Physical page to load |
| dat_hit | input | 1 | Hit flag to load (must be 1 to allow entry writes) |
| dat_way | input | 2 | Way selector to load |
| cmd_we | input | 1 | Command write strobe, starts the operation |
| cmd_op | input | 1 | 0 = entry write, 1 = lookup |
| cmd_lpn | input | 20 | Linear page number |
| cmd_valid | input | 1 | Valid bit to store or compare |
| cmd_apos | input | 3 | Attribute bits (dirty, user, write) |
| cmd_aneg | input | 3 | Complement attribute bits |
| rd_ppn | output | 20 | Data register: physical page |
| rd_hit | output | 1 | Data register: hit flag |
| rd_way | output | 2 | Data register: way selector |
| rd_apos | output | 3 | Attribute readback, bit form |
| rd_aneg | output | 3 | Attribute readback, complement form |
| done | output | 1 | One-cycle pulse after a command write |

## Verification
All 32 entries are filled with distinct tags, pages and attribute patterns. Each entry is then looked up with exact attribute pairs, which separates way and set decoding. The same entries are looked up with the 00 and 11 pairs, which tells the don't-care path apart from an exact compare. A single flipped required attribute bit must turn a hit into a miss, and so must a cleared valid bit. Duplicate tags in one set, writes refused by a clear hit flag, lookups of the all-zero reset entries with valid=0, and a flush before and alongside a write cover the multi-match, refusal and invalidation paths.

// File: rtl/tlb_tp_pkg.sv
`timescale 1ns/1ps
package tlb_tp_pkg;
    localparam int WAYS  = 4;
    localparam int SETS  = 8;
    localparam int LPN_W = 20;
    localparam int PPN_W = 20;
    localparam int NATTR = 3;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = LPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             vld;
        logic [NATTR-1:0] attr;
        logic [PPN_W-1:0] ppn;
    } entry_t;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             hit;
        logic [WAY_W-1:0] way;
        logic [NATTR-1:0] apos;
        logic [NATTR-1:0] aneg;
        logic             done;
    } port_state_t;
endpackage

// File: rtl/tlb_tp_way_cmp.sv
`timescale 1ns/1ps
module tlb_tp_way_cmp
    import tlb_tp_pkg::*;
(
    input  entry_t           ent,
    input  logic [TAG_W-1:0] tag,
    input  logic             vld,
    input  logic [NATTR-1:0] apos,
    input  logic [NATTR-1:0] aneg,
    output logic             match
);
    always_comb begin
        match = (ent.tag == tag) && (ent.vld == vld);
        for (int i = 0; i < NATTR; i++) begin
            // (1,0) demands a stored 1, (0,1) demands a stored 0
            if (apos[i] && !aneg[i] && !ent.attr[i]) match = 1'b0;
            if (!apos[i] && aneg[i] && ent.attr[i])  match = 1'b0;
        end
    end
endmodule

// File: rtl/tlb_tp_sel.sv
`timescale 1ns/1ps
module tlb_tp_sel
    import tlb_tp_pkg::*;
(
    input  logic [WAYS-1:0]  hits,
    output logic             one_hit,
    output logic [WAY_W-1:0] way
);
    logic [WAY_W:0] cnt;

    always_comb begin
        cnt = '0;
        way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hits[i]) begin
                cnt = cnt + 1'b1;
                way = WAY_W'(i);
            end
        end
        one_hit = (cnt == 1);
    end
endmodule

// File: rtl/tlb_test_port.sv
`timescale 1ns/1ps
module tlb_test_port
    import tlb_tp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             dat_we,
    input  logic [PPN_W-1:0] dat_ppn,
    input  logic             dat_hit,
    input  logic [WAY_W-1:0] dat_way,
    input  logic             cmd_we,
    input  logic             cmd_op,
    input  logic [LPN_W-1:0] cmd_lpn,
    input  logic             cmd_valid,
    input  logic [NATTR-1:0] cmd_apos,
    input  logic [NATTR-1:0] cmd_aneg,
    output logic [PPN_W-1:0] rd_ppn,
    output logic             rd_hit,
    output logic [WAY_W-1:0] rd_way,
    output logic [NATTR-1:0] rd_apos,
    output logic [NATTR-1:0] rd_aneg,
    output logic             done
);
    port_state_t st_d, st_q;
    entry_t      mem_d [WAYS][SETS];
    entry_t      mem_q [WAYS][SETS];

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    entry_t           way_ent [WAYS];
    logic [WAYS-1:0]  way_hit;
    logic             one_hit;
    logic [WAY_W-1:0] sel_way;
    entry_t           new_ent;

    assign idx = cmd_lpn[IDX_W-1:0];
    assign tag = cmd_lpn[LPN_W-1:IDX_W];

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign way_ent[g] = mem_q[g][idx];
        tlb_tp_way_cmp u_cmp (
            .ent   (way_ent[g]),
            .tag   (tag),
            .vld   (cmd_valid),
            .apos  (cmd_apos),
            .aneg  (cmd_aneg),
            .match (way_hit[g])
        );
    end

    tlb_tp_sel u_sel (
        .hits    (way_hit),
        .one_hit (one_hit),
        .way     (sel_way)
    );

    always_comb begin
        new_ent.tag  = tag;
        new_ent.vld  = cmd_valid;
        new_ent.attr = cmd_apos & ~cmd_aneg;
        new_ent.ppn  = st_q.ppn;
    end

    always_comb begin
        st_d      = st_q;
        mem_d     = mem_q;
        st_d.done = 1'b0;
        if (dat_we) begin
            st_d.ppn = dat_ppn;
            st_d.hit = dat_hit;
            st_d.way = dat_way;
        end
        if (cmd_we) begin
            st_d.done = 1'b1;
            st_d.apos = cmd_apos;
            st_d.aneg = cmd_aneg;
            if (cmd_op) begin
                st_d.hit = one_hit;
                if (one_hit) begin
                    st_d.ppn  = way_ent[sel_way].ppn;
                    st_d.way  = sel_way;
                    st_d.apos = way_ent[sel_way].attr;
                    st_d.aneg = ~way_ent[sel_way].attr;
                end else begin
                    st_d.ppn = '0;
                    st_d.way = '0;
                end
            end else if (st_q.hit) begin
                mem_d[st_q.way][idx] = new_ent;
            end
        end
        if (flush) begin
            for (int w = 0; w < WAYS; w++)
                for (int s = 0; s < SETS; s++)
                    mem_d[w][s].vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int w = 0; w < WAYS; w++)
                for (int s = 0; s < SETS; s++)
                    mem_q[w][s] <= '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign rd_ppn  = st_q.ppn;
    assign rd_hit  = st_q.hit;
    assign rd_way  = st_q.way;
    assign rd_apos = st_q.apos;
    assign rd_aneg = st_q.aneg;
    assign done    = st_q.done;
endmodule

// File: rtl/tlb_tp_chk.sv
`timescale 1ns/1ps
module tlb_tp_chk
    import tlb_tp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             dat_we,
    input logic [PPN_W-1:0] dat_ppn,
    input logic             dat_hit,
    input logic [WAY_W-1:0] dat_way,
    input logic             cmd_we,
    input logic             cmd_op,
    input logic             cmd_valid,
    input logic [PPN_W-1:0] rd_ppn,
    input logic             rd_hit,
    input logic [WAY_W-1:0] rd_way,
    input logic [NATTR-1:0] rd_apos,
    input logic [NATTR-1:0] rd_aneg,
    input logic             done
);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> done);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> !done);
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_op) |=> (rd_hit || (rd_ppn == '0 && rd_way == '0)));
    assert_hit_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_op) |=> (!rd_hit || (rd_apos == ~rd_aneg)));
    assert_dreg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !cmd_we) |=> (rd_ppn == $past(dat_ppn) && rd_hit == $past(dat_hit)
                                 && rd_way == $past(dat_way)));
    assert_write_keeps_dreg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !cmd_op && !dat_we) |=> ($stable(rd_ppn) && $stable(rd_hit) && $stable(rd_way)));
    assert_flush_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && cmd_we && cmd_op && cmd_valid) |=> !rd_hit);
endmodule

bind tlb_test_port tlb_tp_chk u_chk (.*);

// File: tb/tlb_test_port_tb.sv
`timescale 1ns/1ps
module tlb_test_port_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        flush = 0;
    logic        dat_we = 0;
    logic [19:0] dat_ppn = 0;
    logic        dat_hit = 0;
    logic [1:0]  dat_way = 0;
    logic        cmd_we = 0;
    logic        cmd_op = 0;
    logic [19:0] cmd_lpn = 0;
    logic        cmd_valid = 0;
    logic [2:0]  cmd_apos = 0;
    logic [2:0]  cmd_aneg = 0;
    logic [19:0] rd_ppn;
    logic        rd_hit;
    logic [1:0]  rd_way;
    logic [2:0]  rd_apos;
    logic [2:0]  rd_aneg;
    logic        done;

    int errors = 0;
    int checks = 0;

    logic [16:0] rtag  [4][8];
    logic        rvld  [4][8];
    logic [2:0]  rattr [4][8];
    logic [19:0] rppn  [4][8];
    logic [19:0] bp = 0;
    logic        bh = 0;
    logic [1:0]  bw = 0;

    always #2.5 clk = ~clk;

    tlb_test_port u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_dreg(input logic [19:0] p, input logic h, input logic [1:0] w);
        @(negedge clk);
        dat_ppn = p; dat_hit = h; dat_way = w; dat_we = 1;
        @(negedge clk);
        dat_we = 0;
        bp = p; bh = h; bw = w;
        chk(rd_ppn == p && rd_hit == h && rd_way == w, "R2 data register load",
            {rd_ppn, rd_hit, rd_way}, {p, h, w});
    endtask

    function automatic bit ref_match(int w, logic [19:0] lpn, logic v, logic [2:0] ap, logic [2:0] an);
        bit m;
        int s = int'(lpn[2:0]);
        m = (rtag[w][s] == lpn[19:3]) && (rvld[w][s] == v);
        for (int i = 0; i < 3; i++) begin
            if (ap[i] && !an[i] && !rattr[w][s][i]) m = 0;
            if (!ap[i] && an[i] && rattr[w][s][i])  m = 0;
        end
        return m;
    endfunction

    task automatic do_cmd(input logic op, input logic [19:0] lpn, input logic v,
                          input logic [2:0] ap, input logic [2:0] an, input logic fl,
                          input string req);
        int cnt = 0;
        int ew = 0;
        int s = int'(lpn[2:0]);
        logic eh;
        logic [19:0] ep;
        logic [1:0] ewy;
        logic [2:0] eap, ean;
        for (int w = 0; w < 4; w++)
            if (ref_match(w, lpn, v, ap, an)) begin cnt++; ew = w; end
        @(negedge clk);
        cmd_op = op; cmd_lpn = lpn; cmd_valid = v; cmd_apos = ap; cmd_aneg = an;
        flush = fl; cmd_we = 1;
        @(negedge clk);
        cmd_we = 0; flush = 0;
        chk(done == 1'b1, "R10 done after command", 64'(done), 64'd1);
        if (op) begin
            eh  = (cnt == 1);
            ep  = eh ? rppn[ew][s] : 20'd0;
            ewy = eh ? 2'(ew) : 2'd0;
            eap = eh ? rattr[ew][s] : ap;
            ean = eh ? ~rattr[ew][s] : an;
            chk(rd_hit == eh && rd_ppn == ep && rd_way == ewy && rd_apos == eap && rd_aneg == ean,
                req, {rd_hit, rd_ppn, rd_way, rd_apos, rd_aneg}, {eh, ep, ewy, eap, ean});
            bh = eh; bp = ep; bw = ewy;
        end else begin
            chk(rd_hit == bh && rd_ppn == bp && rd_way == bw && rd_apos == ap && rd_aneg == an,
                "R3 write keeps data register", {rd_hit, rd_ppn, rd_way, rd_apos, rd_aneg},
                {bh, bp, bw, ap, an});
            if (bh) begin
                rtag[bw][s] = lpn[19:3]; rvld[bw][s] = v;
                rattr[bw][s] = ap & ~an; rppn[bw][s] = bp;
            end
        end
        if (fl)
            for (int w = 0; w < 4; w++)
                for (int k = 0; k < 8; k++) rvld[w][k] = 0;
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle wide", 64'(done), 64'd0);
    endtask

    function automatic logic [19:0] lpn_of(int w, int s);
        logic [16:0] t = 17'((w * 8 + s) * 13 + 1);
        return {t, 3'(s)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 8; s++) begin
                rtag[w][s] = 0; rvld[w][s] = 0; rattr[w][s] = 0; rppn[w][s] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk({rd_ppn, rd_hit, rd_way, rd_apos, rd_aneg, done} == '0, "R11 outputs after reset",
            64'({rd_ppn, rd_hit, rd_way, rd_apos, rd_aneg, done}), 64'd0);
        do_cmd(1, 20'd0, 1, 3'b000, 3'b000, 0, "R11 R6 valid lookup misses empty array");
        do_cmd(1, 20'd0, 0, 3'b000, 3'b000, 0, "R7 R6 four zero entries match, miss");

        do_dreg(20'hABCDE, 1, 2'd2);

        // R1 fill every way and set
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 8; s++) begin
                do_dreg(20'((w * 8 + s) * 37 + 5), 1, 2'(w));
                do_cmd(0, lpn_of(w, s), 1, 3'((w + s) % 8), ~3'((w + s) % 8), 0, "R3");
            end

        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 8; s++) begin
                logic [2:0] a = 3'((w + s) % 8);
                do_cmd(1, lpn_of(w, s), 1, a, ~a, 0, "R1 R4 exact lookup");
                do_cmd(1, lpn_of(w, s), 1, 3'b000, 3'b000, 0, "R5 pair 00 is don't care");
                do_cmd(1, lpn_of(w, s), 1, 3'b111, 3'b111, 0, "R5 pair 11 is don't care");
                do_cmd(1, lpn_of(w, s), 1, a ^ 3'(1 << (s % 3)), ~(a ^ 3'(1 << (s % 3))), 0,
                       "R5 wrong attribute misses");
                do_cmd(1, lpn_of(w, s), 0, a, ~a, 0, "R6 valid compared as tag bit");
            end

        // R3 refused write with hit flag 0
        do_dreg(20'h12345, 0, 2'd1);
        do_cmd(0, 20'hFFFF3, 1, 3'b000, 3'b111, 0, "R3");
        do_cmd(1, 20'hFFFF3, 1, 3'b000, 3'b000, 0, "R3 refused write not stored");

        // R5 pairs 00/11 store 0
        do_dreg(20'h0BEEF, 1, 2'd3);
        do_cmd(0, 20'h7777C, 1, 3'b110, 3'b110, 0, "R3");
        do_cmd(1, 20'h7777C, 1, 3'b000, 3'b111, 0, "R5 undefined pairs stored as zero");

        // R7 duplicate tag in another way
        do_dreg(20'h0CAFE, 1, 2'd0);
        do_cmd(0, 20'h7777C, 1, 3'b000, 3'b111, 0, "R3");
        do_cmd(1, 20'h7777C, 1, 3'b000, 3'b000, 0, "R7 double match is a miss");

        // R9 flush
        do_cmd(1, lpn_of(2, 5), 1, 3'b000, 3'b000, 1, "R9 lookup alongside flush sees old array");
        for (int s = 0; s < 8; s++)
            do_cmd(1, lpn_of(1, s), 1, 3'b000, 3'b000, 0, "R9 flushed entry misses");
        do_cmd(1, lpn_of(1, 2), 0, 3'b000, 3'b000, 0, "R9 R6 flushed entry found with valid 0");
        do_dreg(20'h00777, 1, 2'd1);
        do_cmd(0, 20'h55551, 1, 3'b000, 3'b111, 1, "R3");
        do_cmd(1, 20'h55551, 1, 3'b000, 3'b000, 0, "R9 flush wins over same-cycle write");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule